// File: doc/BRIEF.md
# Indirect Configuration Access Bridge

This block lets a host processor reach configuration space through two 32-bit registers in its local register space. The host first writes a target selector word (bus, device, function, dword register number and an enable flag) into the selector register. It then reads or writes the data window. Each window access that is allowed becomes one configuration transaction on a request/acknowledge interface toward a configuration target.

A read through the window always returns the whole dword, and software extracts sub-word fields by shifting. Writes may be byte, halfword or word sized. The low two offset bits of the configuration register are not kept in the selector. They are given by where inside the window the write lands, and the block turns that position and the access size into byte enables for the target. While a transaction is outstanding, the host sees its ready signal held low.

Top module: `cfg_window_bridge`

## Requirements
- R1: After reset the selector register reads 0x00000000, its enable flag is clear and `cfg_req` is low.
- R2: The selector register sits at byte offsets 0x28..0x2B. Only bits 31 and 23:2 are stored, and all other bits read as zero. A byte or halfword write updates only the lanes it covers.
- R3: A transaction carries selector bits 23:16 on `cfg_bus`, 15:11 on `cfg_dev`, 10:8 on `cfg_fn` and 7:2 on `cfg_reg`.
- R4: With the enable flag set, a read anywhere in 0x2C..0x2F issues one target read with `cfg_be` = 4'b1111 and returns the target's dword unchanged, whatever the offset and size.
- R5: A word write (`h_size`=2) at 0x2C issues one target write with `cfg_be` = 4'b1111 and `cfg_wdata` equal to `h_wdata`.
- R6: A halfword write (`h_size`=1) at 0x2C uses `cfg_be` = 4'b0011 and at 0x2E uses 4'b1100. Data stays on its host byte lanes.
- R7: A byte write (`h_size`=0) at 0x2C+k uses `cfg_be` with only bit k set.
- R8: A write with `h_size`=3, a halfword write at an odd offset, or a word write at a nonzero offset is dropped. No transaction is issued and `h_ready` is high in the same cycle.
- R9: With the enable flag clear, a window read returns 0xFFFFFFFF and a window write is dropped. No transaction is issued and `h_ready` is high in the same cycle.
- R10: While `cfg_req` is high, `h_ready` is low and the request fields are held until `cfg_ack`. `h_ready` rises with the result in the cycle after the acknowledge.
- R11: Offsets outside the two registers read as zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| h_valid | input | 1 | Host access request, held until `h_ready` |
| h_write | input | 1 | 1 = write, 0 = read |
| h_addr | input | AW | Byte offset in the bridge register space |
| h_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 illegal |
| h_wdata | input | 32 | Write data on natural byte lanes |
| h_ready | output | 1 | Access completes in this cycle |
| h_rdata | output | 32 | Read data, valid with `h_ready` |
| cfg_req | output | 1 | Configuration transaction pending |
| cfg_we | output | 1 | Transaction is a write |
| cfg_bus | output | 8 | Bus number |
| cfg_dev | output | 5 | Device number |
| cfg_fn | output | 3 | Function number |
| cfg_reg | output | 6 | Dword register number |
| cfg_be | output | 4 | Byte enables |
| cfg_wdata | output | 32 | Write data |
| cfg_ack | input | 1 | Target completes the transaction |
| cfg_rdata | input | 32 | Target read data, valid with `cfg_ack` |

## Verification
The assertions rely on three things. The host keeps `h_valid` and its access fields steady until it sees `h_ready`. The target raises `cfg_ack` only while `cfg_req` is high. The selector is never rewritten during a transaction.

The bench respects all three. Its host task holds every input until the ready cycle and then drops `h_valid`. Its target model answers only an observed request, after a chosen delay. Tests reprogram the selector only between completed accesses.

// File: rtl/cfg_window_bridge.sv
module cfg_window_bridge #(
  parameter int AW = 8,
  parameter logic [AW-1:0] SEL_OFS = 8'h28,
  parameter logic [AW-1:0] WIN_OFS = 8'h2C
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          h_valid,
  input  logic          h_write,
  input  logic [AW-1:0] h_addr,
  input  logic [1:0]    h_size,
  input  logic [31:0]   h_wdata,
  output logic          h_ready,
  output logic [31:0]   h_rdata,
  output logic          cfg_req,
  output logic          cfg_we,
  output logic [7:0]    cfg_bus,
  output logic [4:0]    cfg_dev,
  output logic [2:0]    cfg_fn,
  output logic [5:0]    cfg_reg,
  output logic [3:0]    cfg_be,
  output logic [31:0]   cfg_wdata,
  input  logic          cfg_ack,
  input  logic [31:0]   cfg_rdata
);
  localparam logic [31:0] SEL_KEEP = 32'h80FF_FFFC;
  localparam int EN_BIT = 31;

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_DONE} st_t;
  st_t st;

  logic [31:0] sel_q, rd_q, lane_mask;
  logic [3:0]  be;
  logic        size_ok, hit_sel, hit_win, idle, launch;
  logic [1:0]  lane;

  assign lane    = h_addr[1:0];
  assign hit_sel = h_addr[AW-1:2] == SEL_OFS[AW-1:2];
  assign hit_win = h_addr[AW-1:2] == WIN_OFS[AW-1:2];
  assign idle    = st == S_IDLE;

  always_comb begin
    be = 4'b0000;
    size_ok = 1'b0;
    case (h_size)
      2'd0: begin be = 4'b0001 << lane; size_ok = 1'b1; end
      2'd1: begin be = lane[1] ? 4'b1100 : 4'b0011; size_ok = !lane[0]; end
      2'd2: begin be = 4'b1111; size_ok = lane == 2'd0; end
      default: begin be = 4'b0000; size_ok = 1'b0; end
    endcase
  end

  always_comb
    for (int i = 0; i < 4; i++) lane_mask[i*8 +: 8] = {8{be[i]}};

  assign launch  = idle && h_valid && hit_win && sel_q[EN_BIT] && (!h_write || size_ok);
  assign h_ready = (idle && h_valid && !launch) || st == S_DONE;

  always_comb begin
    if (st == S_DONE) h_rdata = rd_q;
    else if (hit_sel) h_rdata = sel_q;
    else if (hit_win) h_rdata = 32'hFFFF_FFFF;
    else              h_rdata = 32'h0;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sel_q <= 32'h0;
    else if (idle && h_valid && h_write && hit_sel && size_ok)
      sel_q <= ((sel_q & ~lane_mask) | (h_wdata & lane_mask)) & SEL_KEEP;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_IDLE;
      cfg_req <= 1'b0;
      cfg_we <= 1'b0;
      cfg_be <= 4'b0;
      cfg_wdata <= 32'h0;
      rd_q <= 32'h0;
    end else begin
      case (st)
        S_IDLE: if (launch) begin
          st <= S_WAIT;
          cfg_req <= 1'b1;
          cfg_we <= h_write;
          cfg_be <= h_write ? be : 4'b1111;
          cfg_wdata <= h_wdata;
        end
        S_WAIT: if (cfg_ack) begin
          st <= S_DONE;
          cfg_req <= 1'b0;
          rd_q <= cfg_rdata;
        end
        default: st <= S_IDLE;
      endcase
    end

  assign cfg_bus = sel_q[23:16];
  assign cfg_dev = sel_q[15:11];
  assign cfg_fn  = sel_q[10:8];
  assign cfg_reg = sel_q[7:2];
endmodule

// File: rtl/cfg_window_bridge_chk.sv
module cfg_window_bridge_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        h_ready,
  input logic        cfg_req,
  input logic        cfg_we,
  input logic [3:0]  cfg_be,
  input logic [31:0] cfg_wdata,
  input logic        cfg_ack,
  input logic [31:0] sel_q
);
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req && !cfg_ack |=> cfg_req && $stable(cfg_be) && $stable(cfg_we) && $stable(cfg_wdata));
  assert_wait_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req |-> !h_ready);
  assert_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req && cfg_ack |=> h_ready && !cfg_req);
  assert_wr_be_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req && cfg_we |-> (cfg_be == 4'hF || cfg_be == 4'h3 || cfg_be == 4'hC || $countones(cfg_be) == 1));
  assert_rd_be_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req && !cfg_we |-> cfg_be == 4'hF);
  assert_enabled_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_req) |-> sel_q[31]);
  assert_sel_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_q & 32'h7F00_0003) == 32'h0);
endmodule

bind cfg_window_bridge cfg_window_bridge_chk u_chk (
  .clk(clk), .rst_n(rst_n), .h_ready(h_ready), .cfg_req(cfg_req), .cfg_we(cfg_we),
  .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_ack(cfg_ack), .sel_q(sel_q)
);

// File: tb/cfg_window_bridge_tb_top.sv
`timescale 1ns/1ps
module cfg_window_bridge_tb_top;
  logic clk = 0, rst_n = 0;
  logic h_valid = 0, h_write = 0;
  logic [7:0] h_addr = 0;
  logic [1:0] h_size = 0;
  logic [31:0] h_wdata = 0, h_rdata, cfg_wdata, cfg_rdata = 0;
  logic h_ready, cfg_req, cfg_we, cfg_ack = 0;
  logic [7:0] cfg_bus; logic [4:0] cfg_dev; logic [2:0] cfg_fn; logic [5:0] cfg_reg; logic [3:0] cfg_be;

  always #4 clk = ~clk;

  cfg_window_bridge dut_i (.*);

  int nchk = 0, nfail = 0, tgt_dly = 0;
  logic [58:0] tq[$]; string tq_tag[$];
  logic [31:0] rq[$]; string rq_tag[$];

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] resp(logic [7:0] b, logic [4:0] d, logic [2:0] f, logic [5:0] r);
    return {r, 2'b01, f, d, b, 8'h5A};
  endfunction

  task automatic exp_tgt(bit we, logic [3:0] be, logic [7:0] b, logic [4:0] d, logic [2:0] f,
                         logic [5:0] r, logic [31:0] wd, string tag);
    tq.push_back({we, be, b, d, f, r, wd}); tq_tag.push_back(tag);
  endtask

  task automatic exp_rd(logic [31:0] v, string tag);
    rq.push_back(v); rq_tag.push_back(tag);
  endtask

  task automatic hacc(bit wr, logic [7:0] a, logic [1:0] sz, logic [31:0] wd, output int lat);
    @(posedge clk); #1;
    h_valid = 1; h_write = wr; h_addr = a; h_size = sz; h_wdata = wr ? wd : 32'h0;
    lat = 0;
    do begin @(negedge clk); lat++; end while (!h_ready);
    @(posedge clk); #1;
    h_valid = 0; h_write = 0; h_wdata = 0;
  endtask

  task automatic set_sel(bit en, logic [7:0] b, logic [4:0] d, logic [2:0] f, logic [5:0] r);
    int l;
    hacc(1, 8'h28, 2'd2, {en, 7'h0, b, d, f, r, 2'b00}, l);
  endtask

  // host-side monitor
  always @(negedge clk) if (rst_n && h_valid && h_ready && !h_write) begin
    if (rq.size() == 0) check("R4 unexpected read result", h_rdata, 64'hX);
    else check(rq_tag.pop_front(), h_rdata, rq.pop_front());
  end

  always @(negedge clk) if (rst_n && cfg_req) check("R10 ready low while pending", h_ready, 0);

  // target model
  initial forever begin
    @(negedge clk);
    if (cfg_req) begin
      if (tq.size() == 0) check("R9 stray transaction", 1, 0);
      else check(tq_tag.pop_front(), {cfg_we, cfg_be, cfg_bus, cfg_dev, cfg_fn, cfg_reg, cfg_wdata}, tq.pop_front());
      repeat (tgt_dly) @(negedge clk);
      cfg_rdata = resp(cfg_bus, cfg_dev, cfg_fn, cfg_reg);
      cfg_ack = 1;
      @(posedge clk); #1 cfg_ack = 0;
    end
  end

  initial begin
    #800000;
    nfail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    int lat;
    repeat (3) @(posedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 cfg_req after reset", cfg_req, 0);
    exp_rd(32'h0, "R1 selector after reset");
    hacc(0, 8'h28, 2'd2, 0, lat);

    // R2 selector storage and lanes
    hacc(1, 8'h28, 2'd2, 32'hFFFF_FFFF, lat);
    exp_rd(32'h80FF_FFFC, "R2 stored bits only");
    hacc(0, 8'h28, 2'd2, 0, lat);
    hacc(1, 8'h2A, 2'd0, 32'h0037_0000, lat);
    exp_rd(32'h8037_FFFC, "R2 byte lane write");
    hacc(0, 8'h28, 2'd2, 0, lat);
    hacc(1, 8'h28, 2'd1, 32'hAAAA_1237, lat);
    exp_rd(32'h8037_1234, "R2 halfword lane write");
    hacc(0, 8'h28, 2'd2, 0, lat);

    // R11 other offsets
    exp_rd(32'h0, "R11 unmapped read");
    hacc(0, 8'h30, 2'd2, 0, lat);
    hacc(1, 8'h00, 2'd2, 32'h1234_5678, lat);
    hacc(1, 8'h24, 2'd2, 32'h1234_5678, lat);
    exp_rd(32'h8037_1234, "R11 unmapped write no effect");
    hacc(0, 8'h28, 2'd2, 0, lat);

    // R9 disabled
    set_sel(0, 8'h12, 5'h06, 3'h1, 6'h05);
    exp_rd(32'hFFFF_FFFF, "R9 disabled read");
    hacc(0, 8'h2C, 2'd2, 0, lat);
    check("R9 disabled read latency", lat, 1);
    hacc(1, 8'h2C, 2'd2, 32'h5555_AAAA, lat);
    check("R9 disabled write latency", lat, 1);

    // R3 R4 R10 reads
    set_sel(1, 8'hA5, 5'h13, 3'h6, 6'h2B);
    tgt_dly = 0;
    exp_tgt(0, 4'hF, 8'hA5, 5'h13, 3'h6, 6'h2B, 0, "R3 read fields");
    exp_rd(resp(8'hA5, 5'h13, 3'h6, 6'h2B), "R4 read data");
    hacc(0, 8'h2C, 2'd2, 0, lat);
    check("R10 latency dly0", lat, 3);
    tgt_dly = 2;
    exp_tgt(0, 4'hF, 8'hA5, 5'h13, 3'h6, 6'h2B, 0, "R4 byte read full be");
    exp_rd(resp(8'hA5, 5'h13, 3'h6, 6'h2B), "R4 byte offset read full dword");
    hacc(0, 8'h2F, 2'd0, 0, lat);
    check("R10 latency dly2", lat, 5);

    // R5 word write
    tgt_dly = 1;
    exp_tgt(1, 4'hF, 8'hA5, 5'h13, 3'h6, 6'h2B, 32'hDEAD_BEEF, "R5 word write");
    hacc(1, 8'h2C, 2'd2, 32'hDEAD_BEEF, lat);
    check("R10 write latency", lat, 4);

    // R6 halfword writes
    tgt_dly = 0;
    exp_tgt(1, 4'h3, 8'hA5, 5'h13, 3'h6, 6'h2B, 32'h0000_CAFE, "R6 low halfword");
    hacc(1, 8'h2C, 2'd1, 32'h0000_CAFE, lat);
    exp_tgt(1, 4'hC, 8'hA5, 5'h13, 3'h6, 6'h2B, 32'hBABE_0000, "R6 high halfword");
    hacc(1, 8'h2E, 2'd1, 32'hBABE_0000, lat);

    // R7 byte writes
    for (int k = 0; k < 4; k++) begin
      logic [31:0] d;
      d = 32'(8'h11 * (k + 1)) << (8 * k);
      exp_tgt(1, 4'b0001 << k, 8'hA5, 5'h13, 3'h6, 6'h2B, d, "R7 byte write lane");
      hacc(1, 8'h2C + 8'(k), 2'd0, d, lat);
    end

    // R8 rejected writes
    hacc(1, 8'h2C, 2'd3, 32'h1, lat);
    check("R8 size3 dropped", lat, 1);
    hacc(1, 8'h2D, 2'd1, 32'h2, lat);
    check("R8 odd halfword dropped", lat, 1);
    hacc(1, 8'h2E, 2'd2, 32'h3, lat);
    check("R8 misaligned word dropped", lat, 1);

    // R3 boundary field values
    set_sel(1, 8'h00, 5'h1F, 3'h0, 6'h3F);
    tgt_dly = 3;
    exp_tgt(0, 4'hF, 8'h00, 5'h1F, 3'h0, 6'h3F, 0, "R3 boundary fields");
    exp_rd(resp(8'h00, 5'h1F, 3'h0, 6'h3F), "R4 boundary read");
    hacc(0, 8'h2C, 2'd2, 0, lat);

    repeat (4) @(negedge clk);
    check("R9 no missing target transactions", tq.size(), 0);
    check("R4 no missing read results", rq.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule